// File: doc/BRIEF.md
# Two-Wire Sequencer Register Slave

This block is a serial two-wire bus slave that lets a host reach the control registers of a power sequencer. It oversamples the clock and data lines with the system clock, filters short glitches, and recognizes START and STOP conditions. It responds to a 7-bit device address and handles single-byte writes and single-byte random reads. A random read starts with a dummy write of the word address, followed by a repeated START.

Two byte-wide registers are reachable. The status register at word address 00h is read-only except for a write-enable latch. It reports three gate-enable flags that come in from the sequencer logic. The shutdown register at word address FFh holds a two-bit code that goes straight out to the gate control. A write to the shutdown register only succeeds while the latch is set. When the latch is clear, the block refuses the data byte by withholding its ACK. SDA is driven as an open-drain output through an active-high output enable.

Top module: `pwrseq_twi_regs`

## Requirements
- R1: An address byte with bits 7:4 equal to 1010b and bits 3:1 equal to dev_sel_i[2:0] is acknowledged: sda_oe_o is high during the ninth SCL high phase. Bit 0 selects read (1) or write (0).
- R2: An address byte whose bits 7:4 differ from 1010b, or whose bits 3:1 differ from dev_sel_i, is not acknowledged. The slave then ignores all further bytes until the next START.
- R3: A read of word address 00h returns {4'b0000, gate_stat_i[2], gate_stat_i[1], gate_stat_i[0], latch}, with the latch in bit 0.
- R4: Writing exactly 01h to word address 00h sets the write-enable latch, and a later status read shows bit 0 set.
- R5: While the latch is 0, the data byte of a write to word address FFh is not acknowledged, and shdn_code_o keeps its value.
- R6: While the latch is 1, a write to FFh is acknowledged and shdn_code_o takes data bits 1:0 once the ninth clock of the data byte begins. A read of FFh returns {6'b0, shdn_code_o}.
- R7: A word address other than 00h and FFh is acknowledged. A write to it changes nothing, and a read of it returns 00h.
- R8: Writing 00h to word address 00h clears the latch. Any other value except 01h leaves the latch unchanged.
- R9: sda_oe_o changes only while SCL is low and is low whenever the bus is idle after a STOP. A STOP sent before the data byte writes nothing.
- R10: After reset, sda_oe_o is 0, shdn_code_o is 0 and the latch is 0.
- R11: A pulse on SDA shorter than FILT_LEN system clocks while SCL is high is not taken as a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, including the slave's own drive |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain) |
| dev_sel_i | input | 3 | Strapped select bits compared against address bits 3:1 |
| gate_stat_i | input | 3 | Gate-enable flags H, M, L (bit 2 to bit 0) |
| shdn_code_o | output | 2 | Remote shutdown code |

## Verification
The assertions assume that SCL and SDA obey the bus rules: a master changes SDA only while SCL is low, except to form START and STOP, and every level is held far longer than the sync-and-filter delay. Under those conditions, a change of the output enable seen with the filtered SCL low is a real protocol property. The stimulus keeps within these limits by driving each bus phase for twelve system clocks and moving SDA only in the middle of an SCL low phase. There is one deliberate exception: a single-clock SDA pulse inside an SCL high phase, used to exercise the filter.

// File: rtl/pwrseq_twi_pkg.sv
package pwrseq_twi_pkg;
  localparam logic [3:0] DEV_TYPE  = 4'b1010;
  localparam logic [7:0] WA_STATUS = 8'h00;
  localparam logic [7:0] WA_SHDN   = 8'hFF;
  localparam int unsigned SHDN_W   = 2;
  localparam int unsigned GATE_N   = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK,
    ST_WAIT_STOP
  } twi_state_e;
endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (smp == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_o <= smp;   // new level held long enough
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import pwrseq_twi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic [7:0] rd_data_i,
  input  logic       wr_refuse_i,
  output logic [7:0] ptr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  twi_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic [6:0] tx_q;
  logic       rw_q;
  logic       start_c, stop_c, rise_c, fall_c, byte_done;

  assign start_c   = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c    = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_c    = scl_i & ~scl_q;
  assign fall_c    = ~scl_i & scl_q;
  assign byte_done = fall_c && (cnt_q == 4'd8);
  assign wr_data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      ptr_o    <= '0;
      wr_stb_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      wr_stb_o <= 1'b0;
      if (start_c) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WADDR, ST_WDATA: begin
            if (rise_c) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:4] == DEV_TYPE && sh_q[3:1] == dev_sel_i) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh_q[0];
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_WAIT_STOP;
                end
              end else if (state_q == ST_WADDR) begin
                ptr_o    <= sh_q;
                sda_oe_o <= 1'b1;
                state_q  <= ST_WADDR_ACK;
              end else if (wr_refuse_i) begin
                state_q <= ST_WAIT_STOP;   // refused: no ACK
              end else begin
                sda_oe_o <= 1'b1;
                wr_stb_o <= 1'b1;
                state_q  <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (fall_c) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q     <= rd_data_i[6:0];
                sda_oe_o <= ~rd_data_i[7];
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_WADDR;
              end
            end
          end
          ST_WADDR_ACK: begin
            if (fall_c) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (fall_c) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WAIT_STOP;
            end
          end
          ST_RDATA: begin
            if (rise_c) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RD_ACK;
            end else if (fall_c) begin
              sda_oe_o <= ~tx_q[6];
              tx_q     <= {tx_q[5:0], 1'b0};
            end
          end
          ST_RD_ACK: begin
            if (rise_c) state_q <= ST_WAIT_STOP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwrseq_twi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        ptr_i,
  input  logic              wr_stb_i,
  input  logic [7:0]        wr_data_i,
  input  logic [GATE_N-1:0] gate_stat_i,
  output logic [7:0]        rd_data_o,
  output logic              wr_refuse_o,
  output logic [SHDN_W-1:0] shdn_code_o,
  output logic              wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o       <= 1'b0;
      shdn_code_o <= '0;
    end else if (wr_stb_i) begin
      if (ptr_i == WA_STATUS) begin
        if (wr_data_i == 8'h01)      wel_o <= 1'b1;
        else if (wr_data_i == 8'h00) wel_o <= 1'b0;
      end else if (ptr_i == WA_SHDN && wel_o) begin
        shdn_code_o <= wr_data_i[SHDN_W-1:0];
      end
    end
  end

  assign wr_refuse_o = (ptr_i == WA_SHDN) && !wel_o;

  always_comb begin
    unique case (ptr_i)
      WA_STATUS: rd_data_o = {{(8-GATE_N-1){1'b0}}, gate_stat_i, wel_o};
      WA_SHDN:   rd_data_o = {{(8-SHDN_W){1'b0}}, shdn_code_o};
      default:   rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/pwrseq_twi_regs.sv
module pwrseq_twi_regs
  import pwrseq_twi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        dev_sel_i,
  input  logic [GATE_N-1:0] gate_stat_i,
  output logic [SHDN_W-1:0] shdn_code_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_f;
  logic [7:0]         ptr, wr_data, rd_data;
  logic               wr_stb, wr_refuse, wel;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    twi_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_raw[g]),
      .line_o(line_f[g])
    );
  end

  twi_slave_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (line_f[0]),
    .sda_i      (line_f[1]),
    .dev_sel_i  (dev_sel_i),
    .rd_data_i  (rd_data),
    .wr_refuse_i(wr_refuse),
    .ptr_o      (ptr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  pwr_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_i      (ptr),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .gate_stat_i(gate_stat_i),
    .rd_data_o  (rd_data),
    .wr_refuse_o(wr_refuse),
    .shdn_code_o(shdn_code_o),
    .wel_o      (wel)
  );
endmodule

// File: rtl/pwrseq_twi_regs_chk.sv
module pwrseq_twi_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_f_i,
  input logic       sda_oe_i,
  input logic [1:0] shdn_i,
  input logic       wel_i,
  input logic       wr_stb_i,
  input logic [7:0] ptr_i,
  input logic [7:0] wr_data_i
);
  p_oe_rise_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_f_i);

  p_oe_fall_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_i) |-> !scl_f_i);

  p_shdn_needs_wel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shdn_i) |-> $past(wel_i));

  p_wel_set_by_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_i) |-> $past(wr_stb_i && ptr_i == 8'h00 && wr_data_i == 8'h01));

  p_stb_not_refused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> !(ptr_i == 8'hFF && !wel_i));
endmodule

bind pwrseq_twi_regs pwrseq_twi_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_f_i  (line_f[0]),
  .sda_oe_i (sda_oe_o),
  .shdn_i   (shdn_code_o),
  .wel_i    (wel),
  .wr_stb_i (wr_stb),
  .ptr_i    (ptr),
  .wr_data_i(wr_data)
);

// File: tb/pwrseq_twi_regs_bench.sv
module pwrseq_twi_regs_bench;
  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b000, gstat = 3'b000;
  logic       sda_oe;
  logic [1:0] shdn;
  wire        sda_line = sda_m & ~sda_oe;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pwrseq_twi_regs u_pwrseq_twi_regs (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .dev_sel_i  (pins),
    .gate_stat_i(gstat),
    .shdn_code_o(shdn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(input bit b, input bit glitch);
    wq(); sda_m = b; wq(); scl_m = 1'b1; wq();
    if (glitch) begin
      sda_m = ~b; @(negedge clk); sda_m = b;
    end
    wq(); scl_m = 1'b0;
  endtask

  task automatic bit_in(output bit b);
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) bit_out(b[i], glitch && i == 4);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(1'b1, 1'b0);   // NACK
  endtask

  task automatic wr_txn(input logic [7:0] wa, input logic [7:0] d, input bit glitch,
                        output bit a0, output bit a1, output bit a2);
    a1 = 0; a2 = 0;
    bus_start();
    send_byte({4'hA, pins, 1'b0}, 1'b0, a0);
    if (a0) begin
      send_byte(wa, 1'b0, a1);
      send_byte(d, glitch, a2);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] wa, output bit ok, output logic [7:0] d);
    bit a0, a1, a2;
    d = 8'hxx;
    bus_start();
    send_byte({4'hA, pins, 1'b0}, 1'b0, a0);
    send_byte(wa, 1'b0, a1);
    bus_start();
    send_byte({4'hA, pins, 1'b1}, 1'b0, a2);
    ok = a0 && a1 && a2;
    if (ok) recv_byte(d);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2, ok;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R10 shdn after reset", shdn, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_txn(8'h00, ok, d);
    chk("R10 latch clear after reset", d, 8'h00);

    // R1/R2: select sweep over all strap settings
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 8; s++) begin
        pins = 3'(p);
        bus_start();
        send_byte({4'hA, 3'(s), 1'b0}, 1'b0, a0);
        bus_stop();
        chk(s == p ? "R1 select match ack" : "R2 select mismatch nack", a0, s == p);
        chk("R9 oe idle after stop", sda_oe, 0);
      end
    end
    pins = 3'b101;
    for (int t = 0; t < 16; t++) begin
      if (t != 10) begin
        bus_start();
        send_byte({4'(t), pins, 1'b0}, 1'b0, a0);
        bus_stop();
        chk("R2 type mismatch nack", a0, 0);
      end
    end
    bus_start();
    send_byte({4'h9, pins, 1'b0}, 1'b0, a0);
    send_byte(8'h00, 1'b0, a1);
    bus_stop();
    chk("R2 bytes ignored after mismatch", a1, 0);

    // R3: status read with every gate pattern
    for (int g = 0; g < 8; g++) begin
      gstat = 3'(g);
      rd_txn(8'h00, ok, d);
      chk("R3 status read acks", ok, 1);
      chk("R3 status byte", d, {4'b0, 3'(g), 1'b0});
    end
    gstat = 3'b000;

    // R5: blocked shutdown write
    wr_txn(8'hFF, 8'h02, 1'b0, a0, a1, a2);
    chk("R5 blocked data nack", a2, 0);
    chk("R5 shdn unchanged", shdn, 0);

    // R9: STOP before data writes nothing
    bus_start();
    send_byte({4'hA, pins, 1'b0}, 1'b0, a0);
    send_byte(8'h00, 1'b0, a1);
    bus_stop();
    rd_txn(8'h00, ok, d);
    chk("R9 aborted write no effect", d, 8'h00);

    // R4: set latch
    wr_txn(8'h00, 8'h01, 1'b0, a0, a1, a2);
    chk("R4 latch write acked", a2, 1);
    rd_txn(8'h00, ok, d);
    chk("R4 latch visible", d, 8'h01);

    // R8: non-exact value keeps latch
    wr_txn(8'h00, 8'h03, 1'b0, a0, a1, a2);
    rd_txn(8'h00, ok, d);
    chk("R8 latch kept on 03h", d, 8'h01);

    // R6: shutdown codes
    for (int c = 1; c <= 4; c++) begin
      wr_txn(8'hFF, 8'(c % 4), 1'b0, a0, a1, a2);
      chk("R6 shdn write acked", a2, 1);
      chk("R6 shdn code out", shdn, c % 4);
      rd_txn(8'hFF, ok, d);
      chk("R6 shdn readback", d, c % 4);
    end
    wr_txn(8'hFF, 8'hFE, 1'b0, a0, a1, a2);
    chk("R6 only low bits used", shdn, 2);

    // R7: unmapped word address
    wr_txn(8'h5A, 8'h03, 1'b0, a0, a1, a2);
    chk("R7 unmapped acks", a0 && a1 && a2, 1);
    chk("R7 unmapped write no effect", shdn, 2);
    rd_txn(8'h5A, ok, d);
    chk("R7 unmapped read acks", ok, 1);
    chk("R7 unmapped read zero", d, 8'h00);
    rd_txn(8'h00, ok, d);
    chk("R7 status untouched", d, 8'h01);

    // R11: SDA glitch during SCL high inside data byte
    wr_txn(8'hFF, 8'h01, 1'b1, a0, a1, a2);
    chk("R11 glitch ignored ack", a2, 1);
    chk("R11 glitch ignored code", shdn, 1);

    // R8: clear latch, then write refused
    wr_txn(8'h00, 8'h00, 1'b0, a0, a1, a2);
    rd_txn(8'h00, ok, d);
    chk("R8 latch cleared", d, 8'h00);
    wr_txn(8'hFF, 8'h03, 1'b0, a0, a1, a2);
    chk("R5 refused after clear", a2, 0);
    chk("R5 shdn held after refuse", shdn, 1);
    chk("R9 oe idle at end", sda_oe, 0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule